// File: doc/BRIEF.md
# Flash Rewrite Control Register Unit

This block holds the software-visible control and status state for an embedded flash rewrite controller. A CPU reaches it through a byte-wide register port: a write strobe with address and data, and a read data output that follows the address without a clock. The block gates two enables. The first is a rewrite-mode enable. The second is a block-rewrite enable. Both are guarded by a protected write sequence: a write of 0 must come directly before the write of 1, and an interrupt request between the two writes voids the attempt.

The same unit collects sticky program and erase error flags from the flash sequencer. It passes a stop request to the flash. It also runs the erase-suspend handshake. Software can request a suspend directly. When interrupt-driven suspend is selected, an interrupt arriving during an erase raises the request on its own. A read-allowed indication tells the CPU when the array may be read. The flash sequencer is represented only by its status inputs.

Register map (2-bit address):
- Address 0, control register. Bit 0 is ready and read-only (1 when the `busy_i` input is low). Bit 1 is the rewrite-mode enable. Bit 2 is the block-rewrite enable. Bit 3 is the stop bit. Bits 5:4 are reserved. Bit 6 is the program error flag and is read-only. Bit 7 is the erase error flag and is read-only.
- Address 1, suspend register. Bit 0 is the suspend enable. Bit 1 is the suspend request. Bit 2 selects interrupt-driven suspend: 0 means suspend is entered by software, 1 means an interrupt raises the request. Bit 3 is read-allowed and read-only. Bits 7:4 are reserved.
- Address 2 and address 3 read as 0 and ignore writes.

Top module: `flash_rw_ctrl`

## Requirements
- R1: After reset the control register reads 8'h01 and the suspend register reads 8'h08. At that point `busy_i`, `erase_busy_i` and `susp_ack_i` are all low, and every enable and request output is 0.
- R2: Control bit 0 reads 1 when `busy_i` is 0 and reads 0 when `busy_i` is 1, in the same cycle.
- R3: A write of 1 to control bit 1 sets rewrite mode only if the previous register write was to the control register with bit 1 = 0. The setting is refused if another register write came in between. It is also refused if `irq_i` was high in any cycle from that previous write through the write of 1. Idle cycles in between do not break the sequence. Writing 0 to bit 1 always clears the mode.
- R4: Control bit 2 follows the same sequence as R3. The arming 0-write must also carry bit 1 = 1. Both that write and the write of 1 must happen while rewrite mode is already on.
- R5: Any write that clears control bit 1 also clears control bit 2 in the same cycle. The block-rewrite enable output is never 1 while rewrite mode is 0.
- R6: Control bit 3 stores whatever is written to it and reads back as written. `stop_o` is bit 3 ANDed with rewrite mode.
- R7: A high `prog_err_i` sets control bit 6, and a high `erase_err_i` sets control bit 7. Each flag stays set until a `clr_status_i` pulse clears both flags on the next clock edge. If an error input is high in the same cycle as the clear, that error input wins.
- R8: Writes to reserved bits (control bits 5:4, suspend bits 7:4) and to read-only bits have no effect. Reserved bits always read 0.
- R9: A write to the suspend register sets the suspend request only if the same write has bit 0 = 1 and bit 1 = 1. Any other write to the suspend register clears the request.
- R10: An interrupt-raised suspend happens when all of the following are true in one cycle: the suspend enable is 1, the mode-select bit is 1, `irq_i` is high and `erase_busy_i` is high. The suspend request is then set on the next edge. With the mode-select bit at 0, `irq_i` never sets the request.
- R11: One cycle after the inputs change, suspend bit 3 and `read_ok_o` equal `!erase_busy_i || susp_ack_i`.
- R12: Writing 0 to the suspend request lowers `susp_req_o` on the next edge, which resumes the erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_i | input | 1 | Interrupt request seen by the CPU |
| busy_i | input | 1 | Sequencer busy with a program or erase |
| erase_busy_i | input | 1 | Auto-erase in progress |
| susp_ack_i | input | 1 | Sequencer has reached erase-suspend |
| prog_err_i | input | 1 | Program terminated with error (pulse) |
| erase_err_i | input | 1 | Erase terminated with error (pulse) |
| clr_status_i | input | 1 | Clear-status command pulse |
| rw_mode_o | output | 1 | Rewrite mode enabled |
| blk_wr_en_o | output | 1 | Block rewrite enabled |
| stop_o | output | 1 | Flash stop request |
| susp_req_o | output | 1 | Erase-suspend request |
| read_ok_o | output | 1 | Flash array may be read |

## Verification
A wrong arming state in a sequence guard has a fixed signature at the ports: an enable either rises after a broken 0-then-1 sequence or stays low after a clean one. The wrong value reads back on the control register one cycle after the write of 1. Lost or stuck error flags appear on the next read of bits 7:6 after the error pulse or the clear. A fault in the suspend logic shows on `susp_req_o` one edge after the interrupt or write that should have changed it, and on `read_ok_o` one edge after the erase status changes. Every fault is therefore visible within one clock of its cause.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd0;
    localparam logic [ADDR_W-1:0] SUSP_ADDR = 2'd1;

    // control register bit positions
    localparam int C_READY = 0;
    localparam int C_MODE  = 1;
    localparam int C_BLK   = 2;
    localparam int C_STOP  = 3;
    localparam int C_PERR  = 6;
    localparam int C_EERR  = 7;

    // suspend register bit positions
    localparam int S_EN    = 0;
    localparam int S_REQ   = 1;
    localparam int S_IRQM  = 2;
    localparam int S_RDOK  = 3;

    localparam int N_ERR   = 2;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic [1:0] rsvd;
        logic stop;
        logic blk;
        logic mode;
        logic ready;
    } ctrl_view_t;

    typedef struct packed {
        logic [3:0] rsvd;
        logic read_ok;
        logic irq_mode;
        logic req;
        logic en;
    } susp_view_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(
        input logic ready, input logic mode, input logic blk,
        input logic stop, input logic [N_ERR-1:0] err);
        ctrl_view_t v;
        v.erase_err = err[1];
        v.prog_err  = err[0];
        v.rsvd      = 2'b00;
        v.stop      = stop;
        v.blk       = blk;
        v.mode      = mode;
        v.ready     = ready;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_susp(
        input logic en, input logic req, input logic irq_mode,
        input logic read_ok);
        susp_view_t v;
        v.rsvd     = 4'b0000;
        v.read_ok  = read_ok;
        v.irq_mode = irq_mode;
        v.req      = req;
        v.en       = en;
        return v;
    endfunction

endpackage

// File: rtl/fr_seq_guard.sv
// One enable bit behind a 0-then-1 write sequence.
module fr_seq_guard (
    input  logic clk,
    input  logic rst,
    input  logic sel_wr,     // write to the register holding this bit
    input  logic other_wr,   // write to any other register
    input  logic irq,
    input  logic allow,      // precondition for arming and for setting
    input  logic wbit,       // written value of this bit
    input  logic force_clr,
    output logic q
);
    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            q     <= 1'b0;
        end else begin
            if (irq)
                arm_q <= 1'b0;
            else if (sel_wr)
                arm_q <= !wbit && allow;
            else if (other_wr)
                arm_q <= 1'b0;

            if (force_clr || (sel_wr && !wbit))
                q <= 1'b0;
            else if (sel_wr && wbit && arm_q && allow && !irq)
                q <= 1'b1;
        end
    end
endmodule

// File: rtl/fr_err_flags.sv
// Sticky error flags; a set in the clear cycle survives.
module fr_err_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)
                f_q <= 1'b0;
            else if (set_i[i])
                f_q <= 1'b1;
            else if (clr_i)
                f_q <= 1'b0;
        end
        assign flag_o[i] = f_q;
    end
endmodule

// File: rtl/fr_susp_ctl.sv
// Erase-suspend handshake: software or interrupt raised request, read gate.
module fr_susp_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sel_wr,
    input  logic w_en,
    input  logic w_req,
    input  logic w_irqm,
    input  logic irq,
    input  logic erase_busy,
    input  logic susp_ack,
    output logic en_o,
    output logic req_o,
    output logic irqm_o,
    output logic read_ok_o
);
    logic en_q, req_q, irqm_q, rdok_q;
    logic auto_set;

    assign auto_set = en_q && irqm_q && irq && erase_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            req_q  <= 1'b0;
            irqm_q <= 1'b0;
            rdok_q <= 1'b1;
        end else begin
            if (sel_wr) begin
                en_q   <= w_en;
                irqm_q <= w_irqm;
            end
            if (auto_set)
                req_q <= 1'b1;
            else if (sel_wr)
                req_q <= w_req && w_en;
            rdok_q <= !erase_busy || susp_ack;
        end
    end

    assign en_o      = en_q;
    assign req_o     = req_q;
    assign irqm_o    = irqm_q;
    assign read_ok_o = rdok_q;
endmodule

// File: rtl/flash_rw_ctrl.sv
module flash_rw_ctrl
    import flash_rw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              irq_i,
    input  logic              busy_i,
    input  logic              erase_busy_i,
    input  logic              susp_ack_i,
    input  logic              prog_err_i,
    input  logic              erase_err_i,
    input  logic              clr_status_i,
    output logic              rw_mode_o,
    output logic              blk_wr_en_o,
    output logic              stop_o,
    output logic              susp_req_o,
    output logic              read_ok_o
);
    logic wr_ctrl, wr_susp, wr_other_ctrl;
    logic mode_q, blk_q, stop_q;
    logic [N_ERR-1:0] err_q;
    logic susp_en_q, irqm_q;

    assign wr_ctrl       = wr_i && (addr_i == CTRL_ADDR);
    assign wr_susp       = wr_i && (addr_i == SUSP_ADDR);
    assign wr_other_ctrl = wr_i && (addr_i != CTRL_ADDR);

    fr_seq_guard u_mode (
        .clk      (clk),
        .rst      (rst),
        .sel_wr   (wr_ctrl),
        .other_wr (wr_other_ctrl),
        .irq      (irq_i),
        .allow    (1'b1),
        .wbit     (wdata_i[C_MODE]),
        .force_clr(1'b0),
        .q        (mode_q)
    );

    fr_seq_guard u_blk (
        .clk      (clk),
        .rst      (rst),
        .sel_wr   (wr_ctrl),
        .other_wr (wr_other_ctrl),
        .irq      (irq_i),
        .allow    (mode_q && wdata_i[C_MODE]),
        .wbit     (wdata_i[C_BLK]),
        .force_clr(wr_ctrl && !wdata_i[C_MODE]),
        .q        (blk_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            stop_q <= 1'b0;
        else if (wr_ctrl)
            stop_q <= wdata_i[C_STOP];
    end

    fr_err_flags #(.N(N_ERR)) u_err (
        .clk   (clk),
        .rst   (rst),
        .set_i ({erase_err_i, prog_err_i}),
        .clr_i (clr_status_i),
        .flag_o(err_q)
    );

    fr_susp_ctl u_susp (
        .clk       (clk),
        .rst       (rst),
        .sel_wr    (wr_susp),
        .w_en      (wdata_i[S_EN]),
        .w_req     (wdata_i[S_REQ]),
        .w_irqm    (wdata_i[S_IRQM]),
        .irq       (irq_i),
        .erase_busy(erase_busy_i),
        .susp_ack  (susp_ack_i),
        .en_o      (susp_en_q),
        .req_o     (susp_req_o),
        .irqm_o    (irqm_q),
        .read_ok_o (read_ok_o)
    );

    always_comb begin
        unique case (addr_i)
            CTRL_ADDR: rdata_o = pack_ctrl(!busy_i, mode_q, blk_q, stop_q, err_q);
            SUSP_ADDR: rdata_o = pack_susp(susp_en_q, susp_req_o, irqm_q, read_ok_o);
            default:   rdata_o = '0;
        endcase
    end

    assign rw_mode_o   = mode_q;
    assign blk_wr_en_o = blk_q;
    assign stop_o      = stop_q && mode_q;
endmodule

// File: rtl/flash_rw_ctrl_chk.sv
module flash_rw_ctrl_chk
    import flash_rw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              irq_i,
    input logic              erase_busy_i,
    input logic              susp_ack_i,
    input logic              prog_err_i,
    input logic              clr_status_i,
    input logic              rw_mode_o,
    input logic              blk_wr_en_o,
    input logic              stop_o,
    input logic              susp_req_o,
    input logic              read_ok_o,
    input logic [N_ERR-1:0]  err_q,
    input logic              susp_en_q,
    input logic              irqm_q
);
    assert_mode_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rw_mode_o) |-> $past(wr_i && addr_i == CTRL_ADDR && wdata_i[C_MODE] && !irq_i));

    assert_blk_under_mode_R5: assert property (@(posedge clk) disable iff (rst)
        blk_wr_en_o |-> rw_mode_o);

    assert_blk_rise_needs_mode_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_wr_en_o) |-> $past(rw_mode_o));

    assert_stop_gated_R6: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> rw_mode_o);

    assert_clear_errors_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_status_i && !prog_err_i) |=> !err_q[0]);

    assert_auto_suspend_R10: assert property (@(posedge clk) disable iff (rst)
        (susp_en_q && irqm_q && irq_i && erase_busy_i) |=> susp_req_o);

    assert_read_blocked_R11: assert property (@(posedge clk) disable iff (rst)
        (erase_busy_i && !susp_ack_i) |=> !read_ok_o);

    assert_resume_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == SUSP_ADDR && !wdata_i[S_REQ] && !(susp_en_q && irqm_q && irq_i && erase_busy_i))
        |=> !susp_req_o);
endmodule

bind flash_rw_ctrl flash_rw_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .irq_i       (irq_i),
    .erase_busy_i(erase_busy_i),
    .susp_ack_i  (susp_ack_i),
    .prog_err_i  (prog_err_i),
    .clr_status_i(clr_status_i),
    .rw_mode_o   (rw_mode_o),
    .blk_wr_en_o (blk_wr_en_o),
    .stop_o      (stop_o),
    .susp_req_o  (susp_req_o),
    .read_ok_o   (read_ok_o),
    .err_q       (err_q),
    .susp_en_q   (susp_en_q),
    .irqm_q      (irqm_q)
);

// File: tb/flash_rw_ctrl_bench.sv
module flash_rw_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       irq_i = 1'b0, busy_i = 1'b0, erase_busy_i = 1'b0, susp_ack_i = 1'b0;
    logic       prog_err_i = 1'b0, erase_err_i = 1'b0, clr_status_i = 1'b0;
    logic       rw_mode_o, blk_wr_en_o, stop_o, susp_req_o, read_ok_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_rw_ctrl u_flash_rw_ctrl (
        .clk(clk), .rst(rst), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_i(irq_i), .busy_i(busy_i),
        .erase_busy_i(erase_busy_i), .susp_ack_i(susp_ack_i),
        .prog_err_i(prog_err_i), .erase_err_i(erase_err_i),
        .clr_status_i(clr_status_i), .rw_mode_o(rw_mode_o),
        .blk_wr_en_o(blk_wr_en_o), .stop_o(stop_o),
        .susp_req_o(susp_req_o), .read_ok_o(read_ok_o)
    );

    // vector: {wr, addr[0], wdata[7:0], irq, exp_ctrl[7:0], exp {mode,blk,stop}}
    localparam int NV = 23;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1,1'b0,8'h02,1'b0,8'h01,3'b000}, // R3 1 without arming
        {1'b1,1'b0,8'h00,1'b0,8'h01,3'b000}, // R3 arm
        {1'b1,1'b0,8'h02,1'b0,8'h03,3'b100}, // R3 accepted
        {1'b1,1'b0,8'h06,1'b0,8'h03,3'b100}, // R4 blk not armed
        {1'b1,1'b0,8'h02,1'b0,8'h03,3'b100}, // R4 arm blk
        {1'b1,1'b0,8'h06,1'b0,8'h07,3'b110}, // R4 blk set
        {1'b1,1'b0,8'h0E,1'b0,8'h0F,3'b111}, // R6 stop with mode on
        {1'b1,1'b0,8'h38,1'b0,8'h09,3'b000}, // R5 R8 mode off clears blk
        {1'b1,1'b0,8'h02,1'b0,8'h03,3'b100}, // R3 previous 0 armed
        {1'b1,1'b0,8'h00,1'b1,8'h01,3'b000}, // R3 clear with irq
        {1'b1,1'b0,8'h02,1'b0,8'h01,3'b000}, // R3 irq disarmed
        {1'b1,1'b0,8'h00,1'b0,8'h01,3'b000},
        {1'b1,1'b1,8'h00,1'b0,8'h01,3'b000}, // other register write
        {1'b1,1'b0,8'h02,1'b0,8'h01,3'b000}, // R3 refused
        {1'b1,1'b0,8'h00,1'b0,8'h01,3'b000},
        {1'b0,1'b0,8'h00,1'b1,8'h01,3'b000}, // idle cycle with irq
        {1'b1,1'b0,8'h02,1'b0,8'h01,3'b000}, // R3 refused
        {1'b1,1'b0,8'h00,1'b0,8'h01,3'b000},
        {1'b0,1'b0,8'h00,1'b0,8'h01,3'b000}, // quiet idle keeps arm
        {1'b1,1'b0,8'h02,1'b0,8'h03,3'b100}, // R3 accepted
        {1'b1,1'b0,8'h0A,1'b0,8'h0B,3'b101}, // R6 stop out
        {1'b1,1'b0,8'h08,1'b0,8'h09,3'b000}, // R6 mode off, bit kept
        {1'b1,1'b0,8'h08,1'b0,8'h09,3'b000}  // R6 stop written while off
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d, input logic irq);
        @(negedge clk);
        wr_i = w; addr_i = a; wdata_i = d; irq_i = irq;
        @(negedge clk);
        wr_i = 1'b0; irq_i = 1'b0; addr_i = 2'd0; wdata_i = 8'h00;
        #0.5;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr_i = a; #0.5; v = rdata_o; addr_i = 2'd0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0; #0.5;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        do_reset();
        rd(2'd0, v); check("R1 ctrl reset", v, 8'h01);
        rd(2'd1, v); check("R1 susp reset", v, 8'h08);
        check("R1 outputs reset", {3'b0, rw_mode_o, blk_wr_en_o, stop_o, susp_req_o, 1'b0}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] e;
            e = VEC[i];
            cyc(e[21], {1'b0, e[20]}, e[19:12], e[11]);
            rd(2'd0, v);
            check($sformatf("R3 vector %0d ctrl", i), v, e[10:3]);
            check($sformatf("R4 vector %0d outs", i), {5'b0, rw_mode_o, blk_wr_en_o, stop_o}, {5'b0, e[2:0]});
        end

        do_reset();
        // R2 ready flag
        busy_i = 1'b1; rd(2'd0, v); check("R2 busy", v, 8'h00);
        busy_i = 1'b0; rd(2'd0, v); check("R2 ready", v, 8'h01);

        // R7 error flags
        @(negedge clk); prog_err_i = 1'b1; @(negedge clk); prog_err_i = 1'b0; #0.5;
        rd(2'd0, v); check("R7 prog err", v, 8'h41);
        @(negedge clk); erase_err_i = 1'b1; @(negedge clk); erase_err_i = 1'b0; #0.5;
        rd(2'd0, v); check("R7 both err", v, 8'hC1);
        repeat (2) @(negedge clk); #0.5;
        rd(2'd0, v); check("R7 sticky", v, 8'hC1);
        @(negedge clk); clr_status_i = 1'b1; @(negedge clk); clr_status_i = 1'b0; #0.5;
        rd(2'd0, v); check("R7 cleared", v, 8'h01);
        @(negedge clk); clr_status_i = 1'b1; prog_err_i = 1'b1;
        @(negedge clk); clr_status_i = 1'b0; prog_err_i = 1'b0; #0.5;
        rd(2'd0, v); check("R7 set wins", v, 8'h41);
        cyc(1'b1, 2'd0, 8'hC1, 1'b0);
        rd(2'd0, v); check("R8 read-only flags", v, 8'h41);

        // R9 software suspend, R11 read gate
        @(negedge clk); erase_busy_i = 1'b1; @(negedge clk); #0.5;
        check("R11 read blocked", {7'b0, read_ok_o}, 8'h00);
        cyc(1'b1, 2'd1, 8'h02, 1'b0);
        check("R9 req without enable", {7'b0, susp_req_o}, 8'h00);
        cyc(1'b1, 2'd1, 8'hF3, 1'b0);
        check("R9 req set", {7'b0, susp_req_o}, 8'h01);
        rd(2'd1, v); check("R8 susp reserved", v, 8'h03);
        cyc(1'b1, 2'd1, 8'h01, 1'b1);
        check("R12 resume", {7'b0, susp_req_o}, 8'h00);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        check("R10 no auto in software mode", {7'b0, susp_req_o}, 8'h00);

        // R10 interrupt-raised suspend
        cyc(1'b1, 2'd1, 8'h05, 1'b0);
        check("R10 idle before irq", {7'b0, susp_req_o}, 8'h00);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        check("R10 auto request", {7'b0, susp_req_o}, 8'h01);
        rd(2'd1, v); check("R10 susp view", v, 8'h07);
        @(negedge clk); susp_ack_i = 1'b1; @(negedge clk); #0.5;
        rd(2'd1, v); check("R11 read allowed at suspend", v, 8'h0F);
        cyc(1'b1, 2'd1, 8'h05, 1'b0);
        check("R12 resume in irq mode", {7'b0, susp_req_o}, 8'h00);
        @(negedge clk); susp_ack_i = 1'b0; erase_busy_i = 1'b0;
        @(negedge clk); #0.5;
        check("R11 read after erase", {7'b0, read_ok_o}, 8'h01);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        check("R10 no auto when idle", {7'b0, susp_req_o}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule